// File: doc/BRIEF.md
# Two-Mode Cross-Bus DMA Engine

This block moves bytes between a wide memory bus, with a 24-bit address, and a narrow peripheral bus, with an 8-bit address. It has eight channels. Each channel holds its own addresses, byte count, direction and trigger mode. Every byte takes one clock cycle. In that cycle the source bus gets a read strobe and the destination bus gets a write strobe. The byte read is forwarded on one shared 8-bit path, so a transfer always crosses from one bus to the other.

A channel in on-demand mode starts when the CPU writes a start mask. The CPU stays stalled until every started channel has drained its count. A channel in per-line mode waits for a horizontal-blank pulse. After each pulse it moves a short burst of at most four bytes. It stops once its count is used up and then reports this through a status bit.

When more than one channel is pending, the lowest-numbered channel is served first. Per-line bursts take precedence over on-demand work.

Top module: `xdma_top`

## Requirements
- R1: After reset, `cpu_stall` is low, no bus strobe is active, and every register reads back as zero.
- R2: Channel c, register r, sits at address c*8+r:
  - r=0, 1, 2: wide address, low, middle and high byte.
  - r=3: narrow address.
  - r=4, 5: byte count, low and high byte.
  - r=6: control. Bit 0 is the direction (0 = wide-to-narrow, 1 = narrow-to-wide). Bit 1 is the mode (0 = on-demand, 1 = per-line). Bit 2 is the read-only done flag.
  - Address 0x40 is the on-demand start mask. Address 0x41 is the per-line arm mask.
- R3: Each moved byte drives exactly one read strobe on the source bus and one write strobe on the other bus in the same cycle. `xfer_data` carries the source read data.
- R4: The wide address of a channel steps by one after each byte, with carry across all 24 bits. The narrow address never changes.
- R5: A count of zero moves 65536 bytes.
- R6: Writing 0x40 starts the on-demand channels whose bit is set. Bits for per-line channels are ignored. `cpu_stall` rises on the next cycle and stays high until the last started byte has moved. Each bit reads back as 1 until its channel completes, then clears.
- R7: Pending on-demand channels run one at a time, lowest index first, each to completion.
- R8: A `hblank` pulse makes each armed per-line channel whose done flag is clear move min(4, remaining) bytes. The channels go in index order, and `cpu_stall` stays low.
- R9: The done flag sets when a channel's count reaches zero. After that, pulses move no bytes for that channel. A write to either count byte clears the flag.
- R10: Per-line bursts preempt on-demand work, which resumes afterwards with `cpu_stall` held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| cpu_stall | output | 1 | Holds the CPU while on-demand work is pending |
| hblank | input | 1 | Horizontal-blank pulse, one cycle |
| wbus_addr | output | 24 | Wide bus address |
| wbus_rd | output | 1 | Wide bus read strobe |
| wbus_wr | output | 1 | Wide bus write strobe |
| wbus_rdata | input | 8 | Wide bus read data |
| nbus_addr | output | 8 | Narrow bus address |
| nbus_rd | output | 1 | Narrow bus read strobe |
| nbus_wr | output | 1 | Narrow bus write strobe |
| nbus_rdata | input | 8 | Narrow bus read data |
| xfer_data | output | 8 | Byte forwarded to the destination bus |

## Verification
The bench targets the following corner cases:

- **Count of one.** An engine with an off-by-one in its completion test would move two bytes or stall one cycle too long.
- **Zero count.** A zero count must give 65536 bytes, not none.
- **Carry across the 24-bit wide address.** A design that steps only the low byte would read back the wrong address.
- **Per-line burst cut.** A channel with ten bytes left must move 4, 4 and then 2 bytes across three pulses, and nothing on the fourth. A design that re-arms a finished channel would wrap its count and keep moving bytes.
- **Start mask on a per-line channel.** A design that honours that bit would raise a stall that never clears.
- **Preemption mid-run.** When a line burst interrupts an on-demand run, the stall length must grow by exactly the burst size. A design that drops or repeats on-demand bytes would give the wrong length.

// File: rtl/xdma_pkg.sv
`timescale 1ns/100ps
package xdma_pkg;
   // per-channel register selector (low three address bits)
   localparam logic [2:0] SEL_WA0  = 3'd0;
   localparam logic [2:0] SEL_WA1  = 3'd1;
   localparam logic [2:0] SEL_WA2  = 3'd2;
   localparam logic [2:0] SEL_NA   = 3'd3;
   localparam logic [2:0] SEL_CNT0 = 3'd4;
   localparam logic [2:0] SEL_CNT1 = 3'd5;
   localparam logic [2:0] SEL_CTRL = 3'd6;

   // global registers
   localparam logic [7:0] ADDR_GP_START = 8'h40;
   localparam logic [7:0] ADDR_LINE_ARM = 8'h41;

   // control bit positions
   localparam int CTL_DIR  = 0;
   localparam int CTL_MODE = 1;
   localparam int CTL_DONE = 2;

   typedef struct packed {
      logic done;
      logic mode;   // 1 = per-line
      logic dir;    // 1 = narrow-to-wide
   } ch_ctrl_t;
endpackage

// File: rtl/xdma_pick.sv
`timescale 1ns/100ps
module xdma_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];
endmodule

// File: rtl/xdma_chan.sv
`timescale 1ns/100ps
module xdma_chan
   import xdma_pkg::*;
#(
   parameter int WA_W  = 24,
   parameter int NA_W  = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [7:0]       cfg_wdata,
   input  logic             step,
   output logic [WA_W-1:0]  waddr,
   output logic [NA_W-1:0]  naddr,
   output ch_ctrl_t         ctrl,
   output logic             last,
   output logic [7:0]       rdata
);
   logic [WA_W-1:0]  wa_q;
   logic [NA_W-1:0]  na_q;
   logic [CNT_W-1:0] cnt_q;
   logic             dir_q, mode_q, done_q;
   logic [23:0]      wa_ext;
   logic [15:0]      cnt_ext;

   assign wa_ext  = 24'(wa_q);
   assign cnt_ext = 16'(cnt_q);
   assign last    = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wa_q   <= '0;
         na_q   <= '0;
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         mode_q <= 1'b0;
         done_q <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_WA0:  wa_q <= WA_W'({wa_ext[23:8], cfg_wdata});
            SEL_WA1:  wa_q <= WA_W'({wa_ext[23:16], cfg_wdata, wa_ext[7:0]});
            SEL_WA2:  wa_q <= WA_W'({cfg_wdata, wa_ext[15:0]});
            SEL_NA:   na_q <= NA_W'(cfg_wdata);
            SEL_CNT0: begin
               cnt_q  <= CNT_W'({cnt_ext[15:8], cfg_wdata});
               done_q <= 1'b0;
            end
            SEL_CNT1: begin
               cnt_q  <= CNT_W'({cfg_wdata, cnt_ext[7:0]});
               done_q <= 1'b0;
            end
            SEL_CTRL: begin
               dir_q  <= cfg_wdata[CTL_DIR];
               mode_q <= cfg_wdata[CTL_MODE];
            end
            default: ;
         endcase
      end else if (step) begin
         wa_q  <= wa_q + 1'b1;
         cnt_q <= cnt_q - 1'b1;
         if (last) done_q <= 1'b1;
      end
   end

   always_comb begin
      case (cfg_sel)
         SEL_WA0:  rdata = wa_ext[7:0];
         SEL_WA1:  rdata = wa_ext[15:8];
         SEL_WA2:  rdata = wa_ext[23:16];
         SEL_NA:   rdata = 8'(na_q);
         SEL_CNT0: rdata = cnt_ext[7:0];
         SEL_CNT1: rdata = cnt_ext[15:8];
         SEL_CTRL: rdata = {5'b0, done_q, mode_q, dir_q};
         default:  rdata = 8'h00;
      endcase
   end

   assign waddr = wa_q;
   assign naddr = na_q;
   assign ctrl  = '{done: done_q, mode: mode_q, dir: dir_q};
endmodule

// File: rtl/xdma_top.sv
`timescale 1ns/100ps
module xdma_top
   import xdma_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int WA_W  = 24,
   parameter int NA_W  = 8,
   parameter int CNT_W = 16,
   parameter int BURST = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [7:0]      cfg_addr,
   input  logic [7:0]      cfg_wdata,
   output logic [7:0]      cfg_rdata,
   output logic            cpu_stall,
   input  logic            hblank,
   output logic [WA_W-1:0] wbus_addr,
   output logic            wbus_rd,
   output logic            wbus_wr,
   input  logic [7:0]      wbus_rdata,
   output logic [NA_W-1:0] nbus_addr,
   output logic            nbus_rd,
   output logic            nbus_wr,
   input  logic [7:0]      nbus_rdata,
   output logic [7:0]      xfer_data
);
   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int BC_W  = (BURST > 1) ? $clog2(BURST) : 1;

   // elaboration-time parameter checks
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("xdma_top: NCH must be 1..8");
   end
   if (WA_W < 9 || WA_W > 24) begin : g_bad_wa
      $error("xdma_top: WA_W must be 9..24");
   end
   if (NA_W < 1 || NA_W > 8) begin : g_bad_na
      $error("xdma_top: NA_W must be 1..8");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("xdma_top: CNT_W must be 9..16");
   end
   if (BURST < 1) begin : g_bad_burst
      $error("xdma_top: BURST must be at least 1");
   end

   // channel state
   logic [WA_W-1:0] ch_wa    [NCH];
   logic [NA_W-1:0] ch_na    [NCH];
   logic [7:0]      ch_rdata [NCH];
   ch_ctrl_t        ch_ctl   [NCH];
   logic [NCH-1:0]  ch_last, mode_vec, done_vec, dir_vec, step_vec;

   // sequencing state
   logic [NCH-1:0]  gp_en_q, hb_pend_q, line_arm_q;
   logic [NCH-1:0]  gp_nxt, hb_nxt;
   logic [BC_W-1:0] burst_q;

   logic [NCH-1:0]  line_gnt, gp_gnt, sel_oh, fin_vec;
   logic            line_any, gp_any, mv;
   logic [IDX_W-1:0] sel_idx, ch_sel;
   logic            sel_last, sel_dir, ch_space, burst_end;

   assign ch_space = (cfg_addr[7:6] == 2'b00) && ({1'b0, cfg_addr[5:3]} < 4'(NCH));
   assign ch_sel   = IDX_W'(cfg_addr[5:3]);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic we_i;
      assign we_i        = cfg_we && ch_space && (cfg_addr[5:3] == 3'(i));
      assign step_vec[i] = mv && sel_oh[i];

      xdma_chan #(
         .WA_W (WA_W),
         .NA_W (NA_W),
         .CNT_W(CNT_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (we_i),
         .cfg_sel  (cfg_addr[2:0]),
         .cfg_wdata(cfg_wdata),
         .step     (step_vec[i]),
         .waddr    (ch_wa[i]),
         .naddr    (ch_na[i]),
         .ctrl     (ch_ctl[i]),
         .last     (ch_last[i]),
         .rdata    (ch_rdata[i])
      );

      assign mode_vec[i] = ch_ctl[i].mode;
      assign done_vec[i] = ch_ctl[i].done;
      assign dir_vec[i]  = ch_ctl[i].dir;
   end

   // arbitration: per-line bursts first, then on-demand, lowest index wins
   xdma_pick #(.N(NCH)) u_pick_line (
      .req(hb_pend_q),
      .gnt(line_gnt),
      .any(line_any)
   );

   xdma_pick #(.N(NCH)) u_pick_gp (
      .req(gp_en_q),
      .gnt(gp_gnt),
      .any(gp_any)
   );

   assign sel_oh = line_any ? line_gnt : gp_gnt;
   assign mv     = line_any | gp_any;

   always_comb begin
      sel_idx = '0;
      for (int i = 0; i < NCH; i++) begin
         if (sel_oh[i]) sel_idx = IDX_W'(i);
      end
   end

   assign sel_last  = ch_last[sel_idx];
   assign sel_dir   = dir_vec[sel_idx];
   assign burst_end = sel_last || (burst_q == BC_W'(BURST - 1));
   assign fin_vec   = sel_oh & {NCH{mv & sel_last}};

   // next-state for the pending masks
   always_comb begin
      gp_nxt = gp_en_q;
      if (!line_any && gp_any && sel_last) gp_nxt = gp_nxt & ~gp_gnt;
      if (cfg_we && cfg_addr == ADDR_GP_START)
         gp_nxt = gp_nxt | (NCH'(cfg_wdata) & ~mode_vec);

      hb_nxt = hb_pend_q;
      if (line_any && burst_end) hb_nxt = hb_nxt & ~line_gnt;
      if (hblank)
         hb_nxt = hb_nxt | (line_arm_q & mode_vec & ~done_vec & ~fin_vec);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gp_en_q    <= '0;
         hb_pend_q  <= '0;
         line_arm_q <= '0;
         burst_q    <= '0;
      end else begin
         gp_en_q   <= gp_nxt;
         hb_pend_q <= hb_nxt;
         if (cfg_we && cfg_addr == ADDR_LINE_ARM) line_arm_q <= NCH'(cfg_wdata);
         if (line_any) burst_q <= burst_end ? '0 : burst_q + 1'b1;
         else          burst_q <= '0;
      end
   end

   // bus side
   assign wbus_addr = ch_wa[sel_idx];
   assign nbus_addr = ch_na[sel_idx];
   assign wbus_rd   = mv & ~sel_dir;
   assign nbus_wr   = mv & ~sel_dir;
   assign nbus_rd   = mv &  sel_dir;
   assign wbus_wr   = mv &  sel_dir;
   assign xfer_data = sel_dir ? nbus_rdata : wbus_rdata;
   assign cpu_stall = |gp_en_q;

   // register read
   always_comb begin
      cfg_rdata = 8'h00;
      if (ch_space)                        cfg_rdata = ch_rdata[ch_sel];
      else if (cfg_addr == ADDR_GP_START)  cfg_rdata = 8'(gp_en_q);
      else if (cfg_addr == ADDR_LINE_ARM)  cfg_rdata = 8'(line_arm_q);
   end
endmodule

// File: rtl/xdma_chk.sv
`timescale 1ns/100ps
module xdma_chk #(
   parameter int NCH   = 8,
   parameter int BURST = 4
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_we,
   input logic hblank,
   input logic cpu_stall,
   input logic wbus_rd,
   input logic wbus_wr,
   input logic nbus_rd,
   input logic nbus_wr
);
   localparam int LIMIT = NCH * BURST;

   logic        hb_seen;
   logic [15:0] line_cnt;
   logic        moving;

   assign moving = wbus_rd | wbus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_seen  <= 1'b0;
         line_cnt <= '0;
      end else begin
         if (hblank) hb_seen <= 1'b1;
         if (hblank) line_cnt <= '0;
         else if (moving && !cpu_stall && line_cnt != 16'hFFFF) line_cnt <= line_cnt + 1'b1;
      end
   end

   // R3
   pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wbus_rd | wbus_wr) == (nbus_rd | nbus_wr));

   // R3
   cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wbus_rd |-> (nbus_wr && !nbus_rd && !wbus_wr));

   // R6
   stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> $past(cfg_we));

   // R6
   stall_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_stall) |-> $past(moving));

   // R1
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_seen && !cpu_stall) |-> !moving);

   // R8
   line_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_cnt <= 16'(LIMIT));
endmodule

bind xdma_top xdma_chk #(.NCH(NCH), .BURST(BURST)) u_chk (.*);

// File: tb/xdma_top_tb.sv
`timescale 1ns/100ps
module xdma_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic        cpu_stall;
   logic        hblank = 1'b0;
   logic [23:0] wbus_addr;
   logic        wbus_rd, wbus_wr;
   logic [7:0]  wbus_rdata;
   logic [7:0]  nbus_addr;
   logic        nbus_rd, nbus_wr;
   logic [7:0]  nbus_rdata;
   logic [7:0]  xfer_data;

   always #2.5 clk = ~clk;

   xdma_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_stall(cpu_stall),
      .hblank(hblank), .wbus_addr(wbus_addr), .wbus_rd(wbus_rd),
      .wbus_wr(wbus_wr), .wbus_rdata(wbus_rdata), .nbus_addr(nbus_addr),
      .nbus_rd(nbus_rd), .nbus_wr(nbus_wr), .nbus_rdata(nbus_rdata),
      .xfer_data(xfer_data)
   );

   // bus models and monitor, all sampled at the falling edge
   logic [7:0] wmem [256];
   logic [7:0] nsrc;
   logic       clr = 1'b0, mem_init = 1'b0;
   int         n_wr_cnt, w_wr_cnt, stall_cyc, n_hit, strobes;
   logic [7:0] n_last, hit_na, o_first, o_second;
   logic       seen2, order_bad;

   assign wbus_rdata = wmem[wbus_addr[7:0]];
   assign nbus_rdata = nsrc;

   function automatic logic [7:0] fill(input int i);
      return 8'(i * 7 + 3);
   endfunction

   always @(negedge clk) begin
      if (mem_init) begin
         for (int i = 0; i < 256; i++) wmem[i] <= fill(i);
      end
      if (clr) begin
         n_wr_cnt <= 0; w_wr_cnt <= 0; stall_cyc <= 0; n_hit <= 0;
         strobes <= 0; n_last <= 8'h00; nsrc <= 8'h00;
         seen2 <= 1'b0; order_bad <= 1'b0;
      end else begin
         if (cpu_stall) stall_cyc <= stall_cyc + 1;
         if (wbus_rd | wbus_wr | nbus_rd | nbus_wr) strobes <= strobes + 1;
         if (nbus_rd) nsrc <= nsrc + 8'h01;
         if (wbus_wr) begin
            wmem[wbus_addr[7:0]] <= xfer_data;
            w_wr_cnt <= w_wr_cnt + 1;
         end
         if (nbus_wr) begin
            n_wr_cnt <= n_wr_cnt + 1;
            n_last   <= xfer_data;
            if (nbus_addr == hit_na) n_hit <= n_hit + 1;
            if (nbus_addr == o_second) seen2 <= 1'b1;
            if (nbus_addr == o_first && seen2) order_bad <= 1'b1;
         end
      end
   end

   int  total = 0, fails = 0;
   logic finished = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic rd_wa(input int ch, output logic [23:0] v);
      logic [7:0] b0, b1, b2;
      rd(8'(ch * 8 + 0), b0);
      rd(8'(ch * 8 + 1), b1);
      rd(8'(ch * 8 + 2), b2);
      v = {b2, b1, b0};
   endtask

   task automatic setup(input int ch, input logic [23:0] wa, input logic [7:0] na,
                        input logic [15:0] cnt, input logic [7:0] ctl);
      wr(8'(ch * 8 + 0), wa[7:0]);
      wr(8'(ch * 8 + 1), wa[15:8]);
      wr(8'(ch * 8 + 2), wa[23:16]);
      wr(8'(ch * 8 + 3), na);
      wr(8'(ch * 8 + 4), cnt[7:0]);
      wr(8'(ch * 8 + 5), cnt[15:8]);
      wr(8'(ch * 8 + 6), ctl);
   endtask

   task automatic mon_clear();
      @(posedge clk); clr = 1'b1;
      @(posedge clk); clr = 1'b0;
   endtask

   task automatic run_gp(input logic [7:0] mask);
      wr(8'h40, mask);
      for (int k = 0; k < 70000 && cpu_stall; k++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic line_pulse();
      @(negedge clk); hblank = 1'b1;
      @(negedge clk); hblank = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   // vector: {ch[3], wide addr[24], narrow addr[8], count[16], dir[1]}
   localparam int NVEC = 5;
   localparam logic [51:0] VEC [NVEC] = '{
      {3'd0, 24'h000010, 8'h21, 16'd5, 1'b0},
      {3'd3, 24'h000040, 8'h22, 16'd1, 1'b0},
      {3'd7, 24'h000080, 8'h23, 16'd9, 1'b1},
      {3'd5, 24'h01FFFE, 8'h24, 16'd4, 1'b0},
      {3'd2, 24'h0000A0, 8'h25, 16'd3, 1'b1}
   };

   initial begin
      logic [7:0]  d;
      logic [23:0] wv;
      hit_na = 8'h00; o_first = 8'hFF; o_second = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mem_init = 1'b1;
      @(negedge clk);
      mem_init = 1'b0;
      mon_clear();

      // R1 reset state
      chk("R1 stall", int'(cpu_stall), 0);
      rd(8'h40, d); chk("R1 start mask", d, 0);
      rd(8'h41, d); chk("R1 arm mask", d, 0);
      rd(8'h06, d); chk("R1 ch0 ctrl", d, 0);
      rd(8'h3C, d); chk("R1 ch7 count", d, 0);
      repeat (4) @(negedge clk);
      chk("R1 no strobes", strobes, 0);

      // table-driven on-demand runs: R2 R3 R4 R6
      for (int v = 0; v < NVEC; v++) begin
         int          ch, cnt;
         logic [23:0] wa;
         logic [7:0]  na;
         logic        dir;
         ch  = int'(VEC[v][51:49]);
         wa  = VEC[v][48:25];
         na  = VEC[v][24:17];
         cnt = int'(VEC[v][16:1]);
         dir = VEC[v][0];
         hit_na = na;
         setup(ch, wa, na, 16'(cnt), {7'b0, dir});
         mon_clear();
         run_gp(8'(1 << ch));
         chk("R6 stall cycles", stall_cyc, cnt);
         rd(8'h40, d); chk("R6 enable self-clear", d, 0);
         if (!dir) begin
            chk("R3 narrow writes", n_wr_cnt, cnt);
            chk("R4 narrow addr fixed", n_hit, cnt);
            chk("R3 last byte", n_last, fill(int'(wa) + cnt - 1));
            chk("R3 no wide writes", w_wr_cnt, 0);
         end else begin
            chk("R3 wide writes", w_wr_cnt, cnt);
            chk("R3 first byte", wmem[wa[7:0]], 0);
            chk("R3 last byte", wmem[8'(int'(wa) + cnt - 1)], 8'(cnt - 1));
         end
         rd_wa(ch, wv); chk("R4 wide addr advance", wv, int'(wa + 24'(cnt)));
         rd(8'(ch * 8 + 3), d); chk("R4 narrow addr kept", d, na);
         rd(8'(ch * 8 + 4), d); chk("R2 count drained", d, 0);
      end

      // R7 priority: ch1 and ch4 started together
      setup(1, 24'h10, 8'h31, 16'd3, 8'h00);
      setup(4, 24'h30, 8'h32, 16'd2, 8'h00);
      o_first = 8'h31; o_second = 8'h32; hit_na = 8'h31;
      mon_clear();
      run_gp(8'h12);
      chk("R7 total bytes", n_wr_cnt, 5);
      chk("R7 ch1 bytes", n_hit, 3);
      chk("R7 order", int'(order_bad), 0);
      chk("R7 stall", stall_cyc, 5);
      o_first = 8'hFF; o_second = 8'hFF;

      // R6 start bit for a per-line channel is ignored
      setup(6, 24'h50, 8'h41, 16'd10, 8'h02);
      mon_clear();
      wr(8'h40, 8'h40);
      repeat (5) @(negedge clk);
      chk("R6 per-line bit ignored stall", int'(cpu_stall), 0);
      rd(8'h40, d); chk("R6 per-line bit ignored mask", d, 0);
      chk("R6 per-line bit ignored bytes", strobes, 0);

      // R8 R9 per-line bursts
      setup(2, 24'h60, 8'h42, 16'd3, 8'h02);
      wr(8'h41, 8'h44);
      o_first = 8'h42; o_second = 8'h41; hit_na = 8'h41;
      mon_clear();
      line_pulse();
      chk("R8 first pulse bytes", n_wr_cnt, 7);
      chk("R8 burst cap", n_hit, 4);
      chk("R8 index order", int'(order_bad), 0);
      chk("R8 no stall", stall_cyc, 0);
      rd(8'h16, d); chk("R9 ch2 done", d, 8'h06);
      rd(8'h36, d); chk("R9 ch6 not done", d, 8'h02);
      o_first = 8'hFF; o_second = 8'hFF;
      mon_clear();
      line_pulse();
      chk("R8 second pulse", n_wr_cnt, 4);
      rd(8'h34, d); chk("R8 ch6 remaining", d, 2);
      mon_clear();
      line_pulse();
      chk("R8 short tail", n_wr_cnt, 2);
      rd(8'h36, d); chk("R9 ch6 done", d, 8'h06);
      mon_clear();
      line_pulse();
      chk("R9 idle after done", n_wr_cnt, 0);

      // R10 per-line preempts on-demand; count write clears done (R9)
      wr(8'h33, 8'h52);
      wr(8'h34, 8'd4);
      rd(8'h36, d); chk("R9 count write clears done", d, 8'h02);
      setup(0, 24'h10, 8'h51, 16'd20, 8'h00);
      hit_na = 8'h52;
      mon_clear();
      wr(8'h40, 8'h01);
      repeat (2) @(negedge clk);
      hblank = 1'b1;
      @(negedge clk);
      hblank = 1'b0;
      for (int k = 0; k < 200 && cpu_stall; k++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk("R10 total bytes", n_wr_cnt, 24);
      chk("R10 burst bytes", n_hit, 4);
      chk("R10 stall spans burst", stall_cyc, 24);
      rd(8'h40, d); chk("R10 mask clear", d, 0);
      wr(8'h41, 8'h00);

      // R5 zero count
      setup(1, 24'h000000, 8'h60, 16'd0, 8'h00);
      mon_clear();
      run_gp(8'h02);
      chk("R5 bytes", n_wr_cnt, 65536);
      chk("R5 stall", stall_cyc, 65536);
      rd_wa(1, wv); chk("R5 wide addr", wv, 24'h010000);

      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL R6 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule